// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers service requests from a set of I/O devices and decides whether the processor should be interrupted. Every device presents a permission bit, a ready bit, a 3-bit priority level and an 8-bit table index. A device counts as live only when permission and ready are both high. Among the live devices, the block picks the one with the highest level. It raises a request to the processor only if that level is strictly above the running program's level and the processor signals that the current instruction has completed.

Once the processor acknowledges, a sequencer enters supervisor state and raises the active level to that of the serviced device. It then pushes the old status word and program counter onto a supervisor stack through a simple memory handshake. Next it reads the service-routine pointer from the table at base 0x0100 plus the device index and hands that pointer to the processor for loading. A return-from-interrupt pulse hands back the saved program counter, stack pointer, level and mode, and returns the block to idle. The processor datapath, the table memory and the stack memory lie outside the block and are reached only through ports.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A device whose permission bit (dev_en) is low never wins arbitration and never causes irq_req, whatever its ready bit and level.
- R2: A device whose ready bit (dev_rdy) is low never wins arbitration and never causes irq_req, whatever its permission bit and level.
- R3: irq_req is high only if the winner's level is strictly greater than cpu_pri; an equal level gives no request.
- R4: Among live devices the highest level wins; on equal levels the lowest device index wins; irq_vec carries the winner's 8-bit index (device i uses dev_pri[3i+2:3i] and dev_vec[8i+7:8i]).
- R5: irq_req is high only while the block is idle and insn_done is high; a request is accepted only in a cycle with irq_req and irq_ack both high, and irq_ack without insn_done starts nothing.
- R6: From the cycle after acceptance, sup_mode is 1 and act_pri equals the serviced level. Two stack writes follow: the status word at SSP_INIT-1 (bit 15 = prior cpu_sup, bits 2:0 = prior cpu_pri, other bits 0), then the program counter at SSP_INIT-2 (SSP_INIT default 0x3000).
- R7: After the pushes, one table read is issued at address 0x0100 + vector. The cycle after its acknowledge, isr_load is high for exactly one cycle, with isr_pc equal to the data read.
- R8: A memory step keeps mem_req, mem_we, mem_addr and mem_wdata stable until mem_ack is seen.
- R9: While a service is in progress (from acceptance until return), irq_req stays low even for a higher live request.
- R10: rti while running the routine gives ctx_restore for one cycle, with ret_pc, ret_sp, ret_pri and ret_sup equal to the values captured at acceptance. From the next cycle, act_pri and sup_mode equal ret_pri and ret_sup and the block is idle again.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_en | input | N_DEV | Per-device permission bits |
| dev_rdy | input | N_DEV | Per-device ready bits |
| dev_pri | input | N_DEV*PRI_W | Packed per-device levels |
| dev_vec | input | N_DEV*VEC_W | Packed per-device table indices |
| cpu_pri | input | PRI_W | Level of the running program |
| cpu_sup | input | 1 | Running program is in supervisor state |
| cpu_pc | input | ADDR_W | Program counter to save |
| cpu_sp | input | ADDR_W | Stack pointer to save |
| insn_done | input | 1 | Current instruction has completed |
| irq_ack | input | 1 | Processor takes the request |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Winning device's table index |
| mem_req | output | 1 | Memory step request |
| mem_we | output | 1 | Memory step is a write |
| mem_addr | output | ADDR_W | Memory step address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory step done |
| mem_rdata | input | DATA_W | Memory read data |
| isr_load | output | 1 | Load isr_pc into the program counter |
| isr_pc | output | ADDR_W | Service routine address |
| rti | input | 1 | Return-from-interrupt pulse |
| ctx_restore | output | 1 | Restore saved context this cycle |
| ret_pc | output | ADDR_W | Saved program counter |
| ret_sp | output | ADDR_W | Saved stack pointer |
| ret_pri | output | PRI_W | Saved level |
| ret_sup | output | 1 | Saved supervisor mode |
| act_pri | output | PRI_W | Active level held by the block |
| sup_mode | output | 1 | Supervisor state held by the block |

## Verification
Two things can fall in the same cycle: the return from a routine and a live request whose level exceeds the level being restored. The bench keeps such a request asserted through the whole service and pulses rti together with insn_done. It expects irq_req to stay low in the rti cycle and to rise in the next cycle, judged against the restored level. A second coincidence is two live devices on the same level. It is provoked by presenting both in one cycle, and the bench expects the lower index's vector on irq_vec.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_SAVE_PSR  = 3'd1,
      ST_SAVE_PC   = 3'd2,
      ST_FETCH_VEC = 3'd3,
      ST_LOAD_PC   = 3'd4,
      ST_RUN_ISR   = 3'd5
   } svc_state_e;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
   parameter int unsigned N_DEV        = 4,
   parameter int unsigned PRI_W        = 3,
   parameter int unsigned VEC_W        = 8,
   parameter bit          LOW_IDX_WINS = 1'b1,
   localparam int unsigned IDX_W       = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
   input  logic [N_DEV-1:0]       dev_en,
   input  logic [N_DEV-1:0]       dev_rdy,
   input  logic [N_DEV*PRI_W-1:0] dev_pri,
   input  logic [N_DEV*VEC_W-1:0] dev_vec,
   output logic                   win_valid,
   output logic [PRI_W-1:0]       win_pri,
   output logic [VEC_W-1:0]       win_vec,
   output logic [IDX_W-1:0]       win_idx
);
   logic [N_DEV-1:0] live;
   assign live = dev_en & dev_rdy;

   generate
      if (LOW_IDX_WINS) begin : g_low_wins
         // Scan upward; only a strictly higher level displaces the holder.
         always_comb begin
            win_valid = 1'b0;
            win_pri   = '0;
            win_idx   = '0;
            for (int i = 0; i < N_DEV; i++) begin
               if (live[i] && (!win_valid || dev_pri[i*PRI_W +: PRI_W] > win_pri)) begin
                  win_valid = 1'b1;
                  win_pri   = dev_pri[i*PRI_W +: PRI_W];
                  win_idx   = IDX_W'(i);
               end
            end
         end
      end else begin : g_high_wins
         // Scan upward; an equal level displaces the holder.
         always_comb begin
            win_valid = 1'b0;
            win_pri   = '0;
            win_idx   = '0;
            for (int i = 0; i < N_DEV; i++) begin
               if (live[i] && (!win_valid || dev_pri[i*PRI_W +: PRI_W] >= win_pri)) begin
                  win_valid = 1'b1;
                  win_pri   = dev_pri[i*PRI_W +: PRI_W];
                  win_idx   = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   assign win_vec = dev_vec[win_idx*VEC_W +: VEC_W];

   // R1, R2: a reported winner is permitted and ready
   always_comb begin
      if (win_valid) begin
         p_winner_live_r1: assert (dev_en[win_idx] && dev_rdy[win_idx]);
      end
   end
endmodule

// File: rtl/prio_irq_svc.sv
module prio_irq_svc
   import prio_irq_pkg::*;
#(
   parameter int unsigned PRI_W    = 3,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned TBL_BASE = 'h0100,
   parameter int unsigned SSP_INIT = 'h3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [PRI_W-1:0]  win_pri,
   input  logic [VEC_W-1:0]  win_vec,
   input  logic [PRI_W-1:0]  cpu_pri,
   input  logic              cpu_sup,
   input  logic [ADDR_W-1:0] cpu_pc,
   input  logic [ADDR_W-1:0] cpu_sp,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              rti,
   output logic              idle,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              isr_load,
   output logic [ADDR_W-1:0] isr_pc,
   output logic              ctx_restore,
   output logic [ADDR_W-1:0] ret_pc,
   output logic [ADDR_W-1:0] ret_sp,
   output logic [PRI_W-1:0]  ret_pri,
   output logic              ret_sup,
   output logic [PRI_W-1:0]  act_pri,
   output logic              sup_mode
);
   localparam logic [ADDR_W-1:0] TBL_ADDR  = ADDR_W'(TBL_BASE);
   localparam logic [ADDR_W-1:0] STACK_TOP = ADDR_W'(SSP_INIT);
   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

   svc_state_e        state_q;
   logic [VEC_W-1:0]  vec_q;
   logic [PRI_W-1:0]  sv_pri_q;
   logic              sv_sup_q;
   logic [ADDR_W-1:0] sv_pc_q;
   logic [ADDR_W-1:0] sv_sp_q;
   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] isr_q;
   logic [DATA_W-1:0] psr_word;

   always_comb begin
      psr_word             = '0;
      psr_word[DATA_W-1]   = sv_sup_q;
      psr_word[PRI_W-1:0]  = sv_pri_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         vec_q    <= '0;
         sv_pri_q <= '0;
         sv_sup_q <= 1'b0;
         sv_pc_q  <= '0;
         sv_sp_q  <= '0;
         sp_q     <= STACK_TOP;
         isr_q    <= '0;
         act_pri  <= '0;
         sup_mode <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  vec_q    <= win_vec;
                  sv_pri_q <= cpu_pri;
                  sv_sup_q <= cpu_sup;
                  sv_pc_q  <= cpu_pc;
                  sv_sp_q  <= cpu_sp;
                  act_pri  <= win_pri;
                  sup_mode <= 1'b1;
                  state_q  <= ST_SAVE_PSR;
               end
            end
            ST_SAVE_PSR: begin
               if (mem_ack) begin
                  sp_q    <= sp_q - ONE;
                  state_q <= ST_SAVE_PC;
               end
            end
            ST_SAVE_PC: begin
               if (mem_ack) begin
                  sp_q    <= sp_q - ONE;
                  state_q <= ST_FETCH_VEC;
               end
            end
            ST_FETCH_VEC: begin
               if (mem_ack) begin
                  isr_q   <= mem_rdata[ADDR_W-1:0];
                  state_q <= ST_LOAD_PC;
               end
            end
            ST_LOAD_PC: begin
               state_q <= ST_RUN_ISR;
            end
            ST_RUN_ISR: begin
               if (rti) begin
                  sp_q     <= sp_q + ONE + ONE;
                  act_pri  <= sv_pri_q;
                  sup_mode <= sv_sup_q;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state_q)
         ST_SAVE_PSR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - ONE;
            mem_wdata = psr_word;
         end
         ST_SAVE_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - ONE;
            mem_wdata = DATA_W'(sv_pc_q);
         end
         ST_FETCH_VEC: begin
            mem_req   = 1'b1;
            mem_addr  = TBL_ADDR + ADDR_W'(vec_q);
         end
         default: ;
      endcase
   end

   assign idle        = (state_q == ST_IDLE);
   assign isr_load    = (state_q == ST_LOAD_PC);
   assign isr_pc      = isr_q;
   assign ctx_restore = (state_q == ST_RUN_ISR) && rti;
   assign ret_pc      = sv_pc_q;
   assign ret_sp      = sv_sp_q;
   assign ret_pri     = sv_pri_q;
   assign ret_sup     = sv_sup_q;

   // R6: every non-idle state runs in supervisor state
   p_sup_in_svc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> sup_mode);

   // R7: the routine address is handed over right after a table read completes
   p_load_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (isr_load && isr_pc == $past(mem_rdata[ADDR_W-1:0])));

   // R8: an unacknowledged memory step holds its request
   p_hold_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R10: a restore brings back the saved level and mode and ends the service
   p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_restore |=> (idle && act_pri == $past(ret_pri) && sup_mode == $past(ret_sup)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int unsigned N_DEV        = 4,
   parameter int unsigned PRI_W        = 3,
   parameter int unsigned VEC_W        = 8,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned TBL_BASE     = 'h0100,
   parameter int unsigned SSP_INIT     = 'h3000,
   parameter bit          LOW_IDX_WINS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_DEV-1:0]       dev_en,
   input  logic [N_DEV-1:0]       dev_rdy,
   input  logic [N_DEV*PRI_W-1:0] dev_pri,
   input  logic [N_DEV*VEC_W-1:0] dev_vec,
   input  logic [PRI_W-1:0]       cpu_pri,
   input  logic                   cpu_sup,
   input  logic [ADDR_W-1:0]      cpu_pc,
   input  logic [ADDR_W-1:0]      cpu_sp,
   input  logic                   insn_done,
   input  logic                   irq_ack,
   output logic                   irq_req,
   output logic [VEC_W-1:0]       irq_vec,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic                   isr_load,
   output logic [ADDR_W-1:0]      isr_pc,
   input  logic                   rti,
   output logic                   ctx_restore,
   output logic [ADDR_W-1:0]      ret_pc,
   output logic [ADDR_W-1:0]      ret_sp,
   output logic [PRI_W-1:0]       ret_pri,
   output logic                   ret_sup,
   output logic [PRI_W-1:0]       act_pri,
   output logic                   sup_mode
);
   localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

   generate
      if (N_DEV < 1) begin : g_chk_ndev
         $error("N_DEV must be at least 1");
      end
      if (PRI_W < 1 || PRI_W >= DATA_W) begin : g_chk_pri
         $error("PRI_W must be at least 1 and below DATA_W");
      end
      if (VEC_W > ADDR_W) begin : g_chk_vec
         $error("VEC_W must not exceed ADDR_W");
      end
      if (ADDR_W > DATA_W) begin : g_chk_addr
         $error("ADDR_W must not exceed DATA_W");
      end
   endgenerate

   logic             win_valid;
   logic [PRI_W-1:0] win_pri;
   logic [VEC_W-1:0] win_vec;
   logic [IDX_W-1:0] win_idx;
   logic             idle;
   logic             accept;

   prio_irq_pick #(
      .N_DEV        (N_DEV),
      .PRI_W        (PRI_W),
      .VEC_W        (VEC_W),
      .LOW_IDX_WINS (LOW_IDX_WINS)
   ) pick_i (
      .dev_en    (dev_en),
      .dev_rdy   (dev_rdy),
      .dev_pri   (dev_pri),
      .dev_vec   (dev_vec),
      .win_valid (win_valid),
      .win_pri   (win_pri),
      .win_vec   (win_vec),
      .win_idx   (win_idx)
   );

   assign irq_req = idle && insn_done && win_valid && (win_pri > cpu_pri);
   assign irq_vec = win_vec;
   assign accept  = irq_req && irq_ack;

   prio_irq_svc #(
      .PRI_W    (PRI_W),
      .VEC_W    (VEC_W),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .TBL_BASE (TBL_BASE),
      .SSP_INIT (SSP_INIT)
   ) svc_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .win_pri     (win_pri),
      .win_vec     (win_vec),
      .cpu_pri     (cpu_pri),
      .cpu_sup     (cpu_sup),
      .cpu_pc      (cpu_pc),
      .cpu_sp      (cpu_sp),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .rti         (rti),
      .idle        (idle),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .isr_load    (isr_load),
      .isr_pc      (isr_pc),
      .ctx_restore (ctx_restore),
      .ret_pc      (ret_pc),
      .ret_sp      (ret_sp),
      .ret_pri     (ret_pri),
      .ret_sup     (ret_sup),
      .act_pri     (act_pri),
      .sup_mode    (sup_mode)
   );

   // R9: no request is raised while a service runs
   p_quiet_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> !irq_req);

   // R5, R6: an accepted request opens a stack write in supervisor state at the serviced level
   p_accept_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> (mem_req && mem_we && sup_mode && act_pri == $past(win_pri)));

   // R3: the level handed over on acceptance is above the interrupted program's level
   p_strict_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> (act_pri > ret_pri));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_DEV = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [N_DEV-1:0]   dev_en = '0;
   logic [N_DEV-1:0]   dev_rdy = '0;
   logic [N_DEV*3-1:0] dev_pri = '0;
   logic [N_DEV*8-1:0] dev_vec = '0;
   logic [2:0]         cpu_pri = '0;
   logic               cpu_sup = 1'b0;
   logic [15:0]        cpu_pc = '0;
   logic [15:0]        cpu_sp = '0;
   logic               insn_done = 1'b0;
   logic               irq_ack = 1'b0;
   logic               irq_req;
   logic [7:0]         irq_vec;
   logic               mem_req, mem_we;
   logic [15:0]        mem_addr, mem_wdata;
   logic               mem_ack = 1'b0;
   logic [15:0]        mem_rdata = '0;
   logic               isr_load;
   logic [15:0]        isr_pc;
   logic               rti = 1'b0;
   logic               ctx_restore;
   logic [15:0]        ret_pc, ret_sp;
   logic [2:0]         ret_pri, act_pri;
   logic               ret_sup, sup_mode;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .dev_en(dev_en), .dev_rdy(dev_rdy),
      .dev_pri(dev_pri), .dev_vec(dev_vec), .cpu_pri(cpu_pri), .cpu_sup(cpu_sup),
      .cpu_pc(cpu_pc), .cpu_sp(cpu_sp), .insn_done(insn_done), .irq_ack(irq_ack),
      .irq_req(irq_req), .irq_vec(irq_vec), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .isr_load(isr_load), .isr_pc(isr_pc), .rti(rti),
      .ctx_restore(ctx_restore), .ret_pc(ret_pc), .ret_sp(ret_sp),
      .ret_pri(ret_pri), .ret_sup(ret_sup), .act_pri(act_pri), .sup_mode(sup_mode)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic set_dev(input int i, input bit en, input bit rdy, input logic [2:0] p, input logic [7:0] v);
      dev_en[i]        = en;
      dev_rdy[i]       = rdy;
      dev_pri[i*3 +: 3] = p;
      dev_vec[i*8 +: 8] = v;
   endtask

   task automatic clear_devs();
      dev_en = '0; dev_rdy = '0; dev_pri = '0; dev_vec = '0;
      insn_done = 1'b0; irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(irq_req == 1'b0 && mem_req == 1'b0, "reset irq_req/mem_req", {irq_req, mem_req}, 0);
      chk(sup_mode == 1'b0 && act_pri == 3'd0, "reset sup_mode/act_pri", {sup_mode, act_pri}, 0);
   endtask

   task automatic t_gating();
      @(negedge clk);
      clear_devs();
      cpu_pri = 3'd0; insn_done = 1'b1;
      set_dev(1, 1'b0, 1'b1, 3'd7, 8'h11);
      #1 chk(irq_req == 1'b0, "R1 disabled device ignored", irq_req, 0);
      set_dev(1, 1'b1, 1'b0, 3'd7, 8'h11);
      #1 chk(irq_req == 1'b0, "R2 unready device ignored", irq_req, 0);
      set_dev(1, 1'b1, 1'b1, 3'd7, 8'h11);
      #1 chk(irq_req == 1'b1 && irq_vec == 8'h11, "R1 R2 live device requests", {irq_req, irq_vec}, {1'b1, 8'h11});
   endtask

   task automatic t_strict();
      @(negedge clk);
      clear_devs();
      insn_done = 1'b1;
      set_dev(0, 1'b1, 1'b1, 3'd3, 8'h05);
      cpu_pri = 3'd3;
      #1 chk(irq_req == 1'b0, "R3 equal level gives no request", irq_req, 0);
      cpu_pri = 3'd2;
      #1 chk(irq_req == 1'b1, "R3 higher level requests", irq_req, 1);
   endtask

   task automatic t_arbitrate();
      @(negedge clk);
      clear_devs();
      insn_done = 1'b1; cpu_pri = 3'd0;
      set_dev(1, 1'b1, 1'b1, 3'd5, 8'h21);
      set_dev(2, 1'b1, 1'b1, 3'd5, 8'h32);
      set_dev(3, 1'b1, 1'b1, 3'd2, 8'h43);
      #1 chk(irq_vec == 8'h21, "R4 tie goes to lower index", irq_vec, 8'h21);
      set_dev(0, 1'b1, 1'b1, 3'd1, 8'h10);
      set_dev(3, 1'b1, 1'b1, 3'd6, 8'h43);
      #1 chk(irq_vec == 8'h43, "R4 higher level beats lower index", irq_vec, 8'h43);
      set_dev(3, 1'b0, 1'b1, 3'd6, 8'h43);
      #1 chk(irq_vec == 8'h21, "R4 R1 disabled top level skipped", irq_vec, 8'h21);
   endtask

   task automatic t_boundary();
      @(negedge clk);
      clear_devs();
      cpu_pri = 3'd0;
      set_dev(2, 1'b1, 1'b1, 3'd4, 8'h22);
      insn_done = 1'b0; irq_ack = 1'b1;
      #1 chk(irq_req == 1'b0, "R5 no request mid-instruction", irq_req, 0);
      @(negedge clk);
      chk(mem_req == 1'b0 && sup_mode == 1'b0, "R5 ack without boundary starts nothing", {mem_req, sup_mode}, 0);
      irq_ack = 1'b0;
   endtask

   task automatic t_service(input logic [2:0] cp, input bit cs, input logic [15:0] pc,
                            input logic [15:0] sp, input logic [15:0] isr);
      logic [15:0] psr;
      psr = {cs, 12'd0, cp};
      @(negedge clk);
      clear_devs();
      cpu_pri = cp; cpu_sup = cs; cpu_pc = pc; cpu_sp = sp;
      set_dev(2, 1'b1, 1'b1, 3'd6, 8'h45);
      insn_done = 1'b1; irq_ack = 1'b1;
      #1 chk(irq_req == 1'b1 && irq_vec == 8'h45, "R5 request at boundary", {irq_req, irq_vec}, {1'b1, 8'h45});
      @(negedge clk);
      irq_ack = 1'b0;
      cpu_pc = 16'h0; cpu_sp = 16'h0;
      chk(sup_mode == 1'b1 && act_pri == 3'd6, "R6 supervisor at serviced level", {sup_mode, act_pri}, {1'b1, 3'd6});
      chk(mem_req && mem_we && mem_addr == 16'h2FFF && mem_wdata == psr, "R6 status push",
          {mem_addr, mem_wdata}, {16'h2FFF, psr});
      chk(irq_req == 1'b0, "R9 no request while busy", irq_req, 0);
      @(negedge clk);
      chk(mem_req && mem_we && mem_addr == 16'h2FFF && mem_wdata == psr, "R8 step held without ack",
          {mem_addr, mem_wdata}, {16'h2FFF, psr});
      mem_ack = 1'b1;
      @(negedge clk);
      chk(mem_req && mem_we && mem_addr == 16'h2FFE && mem_wdata == pc, "R6 pc push",
          {mem_addr, mem_wdata}, {16'h2FFE, pc});
      @(negedge clk);
      chk(mem_req && !mem_we && mem_addr == 16'h0145, "R7 table read address", mem_addr, 16'h0145);
      mem_rdata = isr;
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = 16'h0;
      chk(isr_load == 1'b1 && isr_pc == isr && mem_req == 1'b0, "R7 routine load", {isr_load, isr_pc}, {1'b1, isr});
      @(negedge clk);
      chk(isr_load == 1'b0, "R7 load lasts one cycle", isr_load, 0);
      chk(irq_req == 1'b0 && sup_mode == 1'b1, "R9 higher request held off in routine", {irq_req, sup_mode}, {1'b0, 1'b1});
      rti = 1'b1;
      #1 chk(ctx_restore && ret_pc == pc && ret_sp == sp && ret_pri == cp && ret_sup == cs,
             "R10 restore values", {ret_pc, ret_sp}, {pc, sp});
      chk(irq_req == 1'b0, "R9 no request on rti cycle", irq_req, 0);
      @(negedge clk);
      rti = 1'b0;
      chk(ctx_restore == 1'b0 && act_pri == cp && sup_mode == cs, "R10 level and mode restored",
          {ctx_restore, act_pri, sup_mode}, {1'b0, cp, cs});
      chk(irq_req == 1'b1, "R3 R10 pending request rises after return", irq_req, 1);
      clear_devs();
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_gating();
      t_strict();
      t_arbitrate();
      t_boundary();
      t_service(3'd1, 1'b0, 16'h3456, 16'hBEEF, 16'h4000);
      t_service(3'd4, 1'b1, 16'h1234, 16'h2F00, 16'h5A5A);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule